// File: doc/BRIEF.md
# TDM Slot Transmit Serializer

The block takes audio words from a 32-entry transmit FIFO and sends them out as a serial bit stream, one word per active slot of a time-division-multiplexed frame. A separate timing generator supplies single-cycle strobes for the rising and falling bit-clock edges. With each strobe it gives a slot-start flag and the index of the current slot. The serializer runs entirely in the system clock domain and uses these strobes as enables.

Word length and slot length are set independently. When the word is shorter than the slot, it is placed at the start or at the end of the slot. Clock polarity selects which bit-clock edge launches data. The number of slots per frame decides which slot indices take a word from the FIFO. A watermark comparison on the FIFO level raises a refill request. If an active slot finds the FIFO empty, the slot is sent as zeros and a sticky underrun flag is set.

Top module: `tdm_tx_serializer`

## Requirements
- R1: After reset, tx_sd is 0, fifo_level is 0, fifo_full is 0, tx_underrun is 0 and tx_req is 1.
- R2: The FIFO holds 32 words. fifo_full is 1 at level 32. A write while the FIFO is full is dropped and leaves the stored words unchanged.
- R3: word_len codes are 0=8, 1=16, 2=20, 3=24 and 4=32 bits. The word is taken from the low bits of the FIFO entry and sent MSB first.
- R4: slot_len codes are 0=8, 1=16 and 2=32 bits. A word longer than its slot sends only its most significant slot-length bits.
- R5: left_just=1 places a shorter word at the start of the slot; left_just=0 places it at the end. All other slot bits are 0.
- R6: clk_pol=0 makes bclk_rise the launch strobe; clk_pol=1 makes bclk_fall the launch strobe. tx_sd changes only on the second clk edge after a launch strobe is sampled. The opposite strobe never changes it.
- R7: A launch strobe with slot_first=1 and slot_idx < num_slots pops exactly one word. Slots with a higher index pop nothing and send zeros.
- R8: An active slot that starts while the FIFO is empty sends all zeros and sets tx_underrun. tx_underrun stays set until reset.
- R9: While tx_en is 0, no word is popped, tx_sd is driven 0 and the FIFO contents are kept. After tx_en returns to 1, output resumes at the next slot start.
- R10: tx_req is 1 when fifo_level is at or below 16 (fifo_quarter=0) or at or below 8 (fifo_quarter=1). It follows the level with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word into the FIFO |
| wr_data | input | 32 | Word to write (low bits used) |
| tx_en | input | 1 | Transmit enable |
| word_len | input | 3 | Word length code |
| slot_len | input | 2 | Slot length code |
| num_slots | input | 4 | Number of active slots per frame (1 to 8) |
| left_just | input | 1 | 1 = word at slot start, 0 = word at slot end |
| clk_pol | input | 1 | Launch edge select |
| bclk_rise | input | 1 | Rising bit-clock strobe |
| bclk_fall | input | 1 | Falling bit-clock strobe |
| slot_first | input | 1 | Strobe marks the first bit of a slot |
| slot_idx | input | 3 | Index of the current slot |
| fifo_quarter | input | 1 | Watermark select: 0 = half, 1 = quarter |
| tx_sd | output | 1 | Serial transmit data |
| fifo_level | output | 6 | Number of words in the FIFO |
| fifo_full | output | 1 | FIFO holds 32 words |
| tx_req | output | 1 | Refill request |
| tx_underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions check on every cycle that the serial output moves only two edges after a launch strobe. They also check that the underrun flag never clears, that the FIFO never exceeds its depth or grows past full, that no word leaves while transmit is disabled or for an inactive slot, and that an empty FIFO always raises the request. The bit patterns for each word-length, slot-length and justification combination can only be shown by the bench's scenarios, which compare every bit with a model of the requirements. The same holds for the exact watermark crossover levels, the zero fill of inactive and underrun slots, and resuming after re-enable.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic [2:0] {
    WLEN_8  = 3'd0,
    WLEN_16 = 3'd1,
    WLEN_20 = 3'd2,
    WLEN_24 = 3'd3,
    WLEN_32 = 3'd4
  } wlen_e;

  typedef enum logic [1:0] {
    SLEN_8  = 2'd0,
    SLEN_16 = 2'd1,
    SLEN_32 = 2'd2
  } slen_e;

  // Bits per word for a word-length code; unused codes mean 32.
  function automatic int word_bits(logic [2:0] code);
    case (wlen_e'(code))
      WLEN_8:  return 8;
      WLEN_16: return 16;
      WLEN_20: return 20;
      WLEN_24: return 24;
      default: return 32;
    endcase
  endfunction

  // Bits per slot for a slot-length code; unused code means 32.
  function automatic int slot_bits(logic [1:0] code);
    case (slen_e'(code))
      SLEN_8:  return 8;
      SLEN_16: return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (count == CNT_FULL);
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  // Storage and registered read port, no reset, so block RAM fits.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r2_level_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);

  a_r2_full_drops_write: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/tdm_tx_watermark.sv
module tdm_tx_watermark #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] count,
  input  logic        quarter,
  output logic        req
);
  localparam logic [AW:0] LIM_HALF  = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] LIM_QUART = (AW+1)'(DEPTH / 4);

  logic [AW:0] limit;

  assign limit = quarter ? LIM_QUART : LIM_HALF;

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b1;
    else     req <= (count <= limit);
  end

  a_r10_empty_requests: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> req);

endmodule

// File: rtl/tdm_tx_slot_fmt.sv
module tdm_tx_slot_fmt
  import tdm_tx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  input  logic [2:0]    wl_code,
  input  logic [1:0]    sl_code,
  input  logic          at_start,
  output logic [DW-1:0] vec
);
  int            wb, sb, sh;
  logic [DW-1:0] mask;

  // Align the word so the first slot bit sits at the vector MSB.
  always_comb begin
    wb   = word_bits(wl_code);
    sb   = slot_bits(sl_code);
    mask = (wb >= DW) ? '1 : ((DW'(1) << wb) - DW'(1));
    if (at_start || (wb >= sb)) sh = DW - wb;
    else                        sh = DW - sb;
    vec  = (word & mask) << sh;
  end

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic          clear,
  input  logic [DW-1:0] vec,
  output logic          sd
);
  logic [DW-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      sd   <= 1'b0;
    end else if (step) begin
      if (clear) begin
        sreg <= '0;
        sd   <= 1'b0;
      end else if (load) begin
        sd   <= vec[DW-1];
        sreg <= vec << 1;
      end else begin
        sd   <= sreg[DW-1];
        sreg <= sreg << 1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int DW        = 32,
  parameter int DEPTH     = 32,
  parameter int MAX_SLOTS = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int SIW      = $clog2(MAX_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_en,
  input  logic [2:0]    word_len,
  input  logic [1:0]    slot_len,
  input  logic [SIW:0]  num_slots,
  input  logic          left_just,
  input  logic          clk_pol,
  input  logic          bclk_rise,
  input  logic          bclk_fall,
  input  logic          slot_first,
  input  logic [SIW-1:0] slot_idx,
  input  logic          fifo_quarter,
  output logic          tx_sd,
  output logic [AW:0]   fifo_level,
  output logic          fifo_full,
  output logic          tx_req,
  output logic          tx_underrun
);
  logic          launch, slot_active, want, pop, empty;
  logic [DW-1:0] head, fmt_vec, load_vec;
  logic          launch_q, first_q, use_q, en_q;

  // Stage 1: pick the launch edge, decide on a pop, issue the FIFO read.
  assign launch      = clk_pol ? bclk_fall : bclk_rise;
  assign slot_active = ({1'b0, slot_idx} < num_slots);
  assign want        = launch && slot_first && tx_en && slot_active;
  assign pop         = want && !empty;

  tdm_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (pop),
    .dout  (head),
    .count (fifo_level),
    .full  (fifo_full),
    .empty (empty)
  );

  tdm_tx_watermark #(.DEPTH(DEPTH)) u_mark (
    .clk     (clk),
    .rst     (rst),
    .count   (fifo_level),
    .quarter (fifo_quarter),
    .req     (tx_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_q    <= 1'b0;
      first_q     <= 1'b0;
      use_q       <= 1'b0;
      en_q        <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      launch_q <= launch;
      first_q  <= launch && slot_first;
      use_q    <= pop;
      en_q     <= tx_en;
      if (want && empty) tx_underrun <= 1'b1;
    end
  end

  // Stage 2: format the popped word (or zeros) and drive the serial line.
  tdm_tx_slot_fmt #(.DW(DW)) u_fmt (
    .word     (head),
    .wl_code  (word_len),
    .sl_code  (slot_len),
    .at_start (left_just),
    .vec      (fmt_vec)
  );

  assign load_vec = use_q ? fmt_vec : '0;

  tdm_tx_shifter #(.DW(DW)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .step  (launch_q),
    .load  (first_q),
    .clear (!en_q),
    .vec   (load_vec),
    .sd    (tx_sd)
  );

  a_r6_sd_moves_after_launch: assert property (@(posedge clk) disable iff (rst)
    !$past(launch, 2) |-> $stable(tx_sd));

  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_underrun);

  a_r9_no_pop_when_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (fifo_level >= $past(fifo_level)));

  a_r7_idle_slot_no_pop: assert property (@(posedge clk) disable iff (rst)
    (launch && slot_first && !slot_active) |=> (fifo_level >= $past(fifo_level)));

endmodule

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tx_en = 1'b1;
  logic [2:0]  word_len = 3'd1;
  logic [1:0]  slot_len = 2'd1;
  logic [3:0]  num_slots = 4'd2;
  logic        left_just = 1'b1;
  logic        clk_pol = 1'b0;
  logic        bclk_rise = 1'b0;
  logic        bclk_fall = 1'b0;
  logic        slot_first = 1'b0;
  logic [2:0]  slot_idx = '0;
  logic        fifo_quarter = 1'b0;
  logic        tx_sd;
  logic [5:0]  fifo_level;
  logic        fifo_full;
  logic        tx_req;
  logic        tx_underrun;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tdm_tx_serializer u_tdm_tx_serializer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .word_len(word_len), .slot_len(slot_len), .num_slots(num_slots),
    .left_just(left_just), .clk_pol(clk_pol), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .slot_first(slot_first), .slot_idx(slot_idx),
    .fifo_quarter(fifo_quarter), .tx_sd(tx_sd), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .tx_req(tx_req), .tx_underrun(tx_underrun)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected slot bits from the requirements, first bit at index 31.
  function automatic logic [31:0] exp_slot(logic [31:0] w, int wl, int sl, bit lj);
    int wb = (wl == 0) ? 8 : (wl == 1) ? 16 : (wl == 2) ? 20 : (wl == 3) ? 24 : 32;
    int sb = (sl == 0) ? 8 : (sl == 1) ? 16 : 32;
    logic [31:0] r = '0;
    for (int k = 0; k < sb; k++) begin
      if (lj || wb >= sb) r[31-k] = (k < wb) ? w[wb-1-k] : 1'b0;
      else                r[31-k] = (k < sb - wb) ? 1'b0 : w[sb-1-k];
    end
    return r;
  endfunction

  function automatic int slot_width(int sl);
    return (sl == 0) ? 8 : (sl == 1) ? 16 : 32;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; bclk_rise = 1'b0; bclk_fall = 1'b0; slot_first = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(input bit on_launch, input bit first, input logic [2:0] idx,
                        output logic sd);
    @(negedge clk);
    if (on_launch ^ clk_pol) bclk_rise = 1'b1; else bclk_fall = 1'b1;
    slot_first = first; slot_idx = idx;
    @(negedge clk);
    bclk_rise = 1'b0; bclk_fall = 1'b0; slot_first = 1'b0;
    @(negedge clk);
    sd = tx_sd;
  endtask

  // Drives one slot bit by bit; the opposite edge must leave tx_sd alone (R6).
  task automatic send_slot(input logic [2:0] idx, input int sb,
                           input logic [31:0] exp, input string req);
    logic b, b2;
    for (int k = 0; k < sb; k++) begin
      strobe(1'b1, k == 0, idx, b);
      chk(b == exp[31-k], req, $sformatf("slot %0d bit %0d", idx, k), {31'b0, b}, {31'b0, exp[31-k]});
      strobe(1'b0, 1'b0, idx, b2);
      chk(b2 == b, "R6", "opposite edge changed tx_sd", {31'b0, b2}, {31'b0, b});
    end
  endtask

  task automatic cfg(input int wl, input int sl, input int n, input bit lj, input bit pol);
    word_len = 3'(wl); slot_len = 2'(sl); num_slots = 4'(n); left_just = lj; clk_pol = pol;
  endtask

  task automatic t_reset();
    do_reset();
    chk(tx_sd == 1'b0, "R1", "tx_sd", {31'b0, tx_sd}, 0);
    chk(fifo_level == 0, "R1", "level", {26'b0, fifo_level}, 0);
    chk(fifo_full == 1'b0, "R1", "full", {31'b0, fifo_full}, 0);
    chk(tx_underrun == 1'b0, "R1", "underrun", {31'b0, tx_underrun}, 0);
    chk(tx_req == 1'b1, "R1", "req", {31'b0, tx_req}, 1);
  endtask

  task automatic t_basic();
    cfg(1, 1, 2, 1'b1, 1'b0); tx_en = 1'b1;
    do_reset();
    push(32'h0000A5C3); push(32'hFFFF1234);
    send_slot(3'd0, 16, exp_slot(32'h0000A5C3, 1, 1, 1'b1), "R3");
    send_slot(3'd1, 16, exp_slot(32'hFFFF1234, 1, 1, 1'b1), "R3");
    chk(fifo_level == 0, "R7", "level after two slots", {26'b0, fifo_level}, 0);
  endtask

  task automatic t_widths();
    int wl, sl; bit lj; logic [31:0] w;
    for (int i = 0; i < 6; i++) begin
      case (i)
        0: begin wl = 0; sl = 1; lj = 1'b0; w = 32'h123456B7; end
        1: begin wl = 2; sl = 2; lj = 1'b1; w = 32'hFF9ABCDE; end
        2: begin wl = 3; sl = 2; lj = 1'b0; w = 32'h00C3A5F1; end
        3: begin wl = 4; sl = 1; lj = 1'b1; w = 32'h9ABCDEF1; end
        4: begin wl = 4; sl = 0; lj = 1'b0; w = 32'hC1234567; end
        default: begin wl = 0; sl = 2; lj = 1'b1; w = 32'h000000E5; end
      endcase
      cfg(wl, sl, 1, lj, 1'b0);
      do_reset();
      push(w);
      send_slot(3'd0, slot_width(sl), exp_slot(w, wl, sl, lj),
                (i == 3 || i == 4) ? "R4" : (i == 0 || i == 2) ? "R5" : "R3");
    end
  endtask

  task automatic t_slots();
    logic [31:0] e;
    cfg(0, 0, 4, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 6; i++) push(32'h81 + 32'(i * 17));
    for (int s = 0; s < 8; s++) begin
      e = (s < 4) ? exp_slot(32'h81 + 32'(s * 17), 0, 0, 1'b1) : 32'h0;
      send_slot(3'(s), 8, e, "R7");
    end
    chk(fifo_level == 2, "R7", "level after frame", {26'b0, fifo_level}, 2);
  endtask

  task automatic t_pol();
    cfg(1, 2, 1, 1'b0, 1'b1);
    do_reset();
    push(32'h00008001);
    send_slot(3'd0, 32, exp_slot(32'h00008001, 1, 2, 1'b0), "R6");
    clk_pol = 1'b0;
  endtask

  task automatic t_enable();
    cfg(1, 1, 1, 1'b1, 1'b0);
    do_reset();
    push(32'h0000C0DE); push(32'h00001357);
    tx_en = 1'b0;
    send_slot(3'd0, 16, 32'h0, "R9");
    chk(fifo_level == 2, "R9", "level while off", {26'b0, fifo_level}, 2);
    tx_en = 1'b1;
    send_slot(3'd0, 16, exp_slot(32'h0000C0DE, 1, 1, 1'b1), "R9");
    chk(fifo_level == 1, "R9", "level after resume", {26'b0, fifo_level}, 1);
  endtask

  task automatic t_water();
    fifo_quarter = 1'b0;
    do_reset();
    for (int i = 0; i < 16; i++) push(32'(i));
    settle();
    chk(tx_req == 1'b1, "R10", "half, level 16", {31'b0, tx_req}, 1);
    push(32'h55); settle();
    chk(tx_req == 1'b0, "R10", "half, level 17", {31'b0, tx_req}, 0);
    fifo_quarter = 1'b1; settle();
    chk(tx_req == 1'b0, "R10", "quarter, level 17", {31'b0, tx_req}, 0);
    do_reset();
    for (int i = 0; i < 8; i++) push(32'(i));
    settle();
    chk(tx_req == 1'b1, "R10", "quarter, level 8", {31'b0, tx_req}, 1);
    push(32'h66); settle();
    chk(tx_req == 1'b0, "R10", "quarter, level 9", {31'b0, tx_req}, 0);
    fifo_quarter = 1'b0; settle();
    chk(tx_req == 1'b1, "R10", "half, level 9", {31'b0, tx_req}, 1);
  endtask

  task automatic t_full();
    cfg(4, 2, 1, 1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 33; i++) push(32'h01010101 * 32'(i + 1));
    chk(fifo_level == 32, "R2", "level after 33 writes", {26'b0, fifo_level}, 32);
    chk(fifo_full == 1'b1, "R2", "full", {31'b0, fifo_full}, 1);
    send_slot(3'd0, 32, exp_slot(32'h01010101, 4, 2, 1'b1), "R2");
    chk(fifo_level == 31, "R2", "level after pop", {26'b0, fifo_level}, 31);
    chk(fifo_full == 1'b0, "R2", "full cleared", {31'b0, fifo_full}, 0);
  endtask

  task automatic t_underflow();
    cfg(1, 1, 1, 1'b1, 1'b0);
    do_reset();
    send_slot(3'd0, 16, 32'h0, "R8");
    chk(tx_underrun == 1'b1, "R8", "underrun set", {31'b0, tx_underrun}, 1);
    push(32'h0000BEEF);
    send_slot(3'd0, 16, exp_slot(32'h0000BEEF, 1, 1, 1'b1), "R8");
    chk(tx_underrun == 1'b1, "R8", "underrun sticky", {31'b0, tx_underrun}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_widths();
    t_slots();
    t_pol();
    t_enable();
    t_water();
    t_full();
    t_underflow();
    finish_run();
  end

endmodule